// File: doc/BRIEF.md
# Coin-Credit Snack Vending Controller

This block is the control state machine of a snack dispenser whose single item costs five half-unit steps (2.5 units of currency). Payment arrives on two separate load lines: one for a half-unit coin and one for a one-unit note. The block's state is the credit collected so far, counted in half-unit steps. Every accepted payment is confirmed by its own one-cycle acknowledge pulse.

Once the credit reaches or goes past the price, the block gives a one-cycle delivery pulse in the same cycle as the acknowledge for that payment. It then takes the price off the credit. Any excess credit is kept toward the next purchase, and no change is ever paid out. A payment is counted only on the clock where its load line is first seen high. If a coin and a note both arrive on the same clock, the note takes priority.

Top module: `snack_credit_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets the credit to zero steps. All three outputs stay low on every cycle that follows a clock at which `rst` was high. Any credit encoding outside 0..PRICE_STEPS-1 goes back to zero on the next clock.
- R2: A coin load line sampled high at a clock edge, after being low at the previous edge, adds one step of credit. It also makes `coin_ack` high for exactly the one cycle after that edge.
- R3: A note load line sampled high at a clock edge, after being low at the previous edge, adds two steps of credit. It also makes `note_ack` high for exactly the one cycle after that edge.
- R4: A load line that stays high over several edges is counted only once. It is counted again only after it has been sampled low.
- R5: If both lines rise at the same edge, only the note is accepted, and `coin_ack` stays low. A coin line that is still high is not counted until it falls and rises again.
- R6: When an accepted payment brings the credit to five steps or more, `vend_pulse` is high in the same cycle as that payment's acknowledge. Five steps are then taken off the credit.
- R7: Credit left over after a delivery is kept. A note inserted at four steps delivers and leaves one step, so the next delivery needs four more steps.
- R8: No change is returned. An exact payment of five steps leaves zero credit, so five further steps are needed before the next delivery.
- R9: `coin_ack` and `note_ack` are never high together. No more than one delivery is made per accepted payment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_half_in | input | 1 | Load line of the half-unit coin |
| note_one_in | input | 1 | Load line of the one-unit note |
| coin_ack | output | 1 | One-cycle pulse confirming an accepted coin |
| note_ack | output | 1 | One-cycle pulse confirming an accepted note |
| vend_pulse | output | 1 | One-cycle pulse that releases one product |

## Verification
The hardest case to reach from the ports is a coin line that loses to a note and is still high afterward. Unless the coin line goes low and high again, the coin must stay uncounted. The bench gets there by raising both lines on one edge, then dropping only the note and holding the coin high for another edge. Only after that does it release the coin and insert it again. The credit is not visible at the ports, so its value is read from when deliveries happen. Leftover credit after a note at four steps, and zero credit after an exact payment, each show up as a different number of payments needed before the next `vend_pulse`.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // One bit per payment kind, used for edge events and for the accepted payment.
  typedef struct packed {
    logic coin;
    logic note;
  } pay_t;

endpackage

// File: rtl/vend_edge_detect.sv
module vend_edge_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_in,
  output logic [W-1:0] rise_out
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_out[i] = level_in[i] & ~prev_q[i];
  end

endmodule

// File: rtl/vend_pay_select.sv
module vend_pay_select
  import vend_pkg::*;
(
  input  pay_t rise_in,
  output pay_t take_out
);

  // When both arrive together the note wins and the coin event is dropped.
  always_comb begin
    take_out.note = rise_in.note;
    take_out.coin = rise_in.coin & ~rise_in.note;
  end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
  import vend_pkg::*;
#(
  parameter int PRICE_STEPS = 5,
  parameter int COIN_STEPS  = 1,
  parameter int NOTE_STEPS  = 2,
  parameter int CRED_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  pay_t              take_in,
  output logic [CRED_W-1:0] credit_q,
  output logic              coin_ack_q,
  output logic              note_ack_q,
  output logic              vend_q
);

  localparam int SUM_W = $clog2(PRICE_STEPS + NOTE_STEPS + 1) + 1;
  localparam logic [SUM_W-1:0] PRICE_S = SUM_W'(PRICE_STEPS);

  logic [SUM_W-1:0]  add_s, sum_s;
  logic              legal_s, reach_s;
  logic [CRED_W-1:0] credit_n;

  always_comb begin
    add_s    = take_in.note ? SUM_W'(NOTE_STEPS) :
               take_in.coin ? SUM_W'(COIN_STEPS) : '0;
    legal_s  = SUM_W'(credit_q) < PRICE_S;
    sum_s    = SUM_W'(credit_q) + add_s;
    reach_s  = legal_s && (sum_s >= PRICE_S);
    if (!legal_s)     credit_n = '0;
    else if (reach_s) credit_n = CRED_W'(sum_s - PRICE_S);
    else              credit_n = CRED_W'(sum_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q   <= '0;
      coin_ack_q <= 1'b0;
      note_ack_q <= 1'b0;
      vend_q     <= 1'b0;
    end else begin
      credit_q   <= credit_n;
      coin_ack_q <= legal_s & take_in.coin;
      note_ack_q <= legal_s & take_in.note;
      vend_q     <= reach_s;
    end
  end

endmodule

// File: rtl/snack_credit_ctrl.sv
module snack_credit_ctrl
  import vend_pkg::*;
#(
  parameter int PRICE_STEPS = 5,
  parameter int COIN_STEPS  = 1,
  parameter int NOTE_STEPS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic coin_half_in,
  input  logic note_one_in,
  output logic coin_ack,
  output logic note_ack,
  output logic vend_pulse
);

  localparam int CRED_W = (PRICE_STEPS > 2) ? $clog2(PRICE_STEPS) : 1;

  pay_t              level_s, rise_s, take_s;
  logic [CRED_W-1:0] credit_q;

  assign level_s.coin = coin_half_in;
  assign level_s.note = note_one_in;

  vend_edge_detect #(.W(2)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (level_s),
    .rise_out (rise_s)
  );

  vend_pay_select u_sel (
    .rise_in  (rise_s),
    .take_out (take_s)
  );

  vend_credit_fsm #(
    .PRICE_STEPS (PRICE_STEPS),
    .COIN_STEPS  (COIN_STEPS),
    .NOTE_STEPS  (NOTE_STEPS),
    .CRED_W      (CRED_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .take_in    (take_s),
    .credit_q   (credit_q),
    .coin_ack_q (coin_ack),
    .note_ack_q (note_ack),
    .vend_q     (vend_pulse)
  );

endmodule

// File: rtl/vend_credit_chk.sv
module vend_credit_chk #(
  parameter int PRICE_STEPS = 5,
  parameter int COIN_STEPS  = 1,
  parameter int NOTE_STEPS  = 2,
  parameter int CRED_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              coin_half_in,
  input logic              note_one_in,
  input logic              coin_ack,
  input logic              note_ack,
  input logic              vend_pulse,
  input logic [CRED_W-1:0] credit
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (credit == '0 && !coin_ack && !note_ack && !vend_pulse));

  // R1
  credit_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(credit) < PRICE_STEPS);

  // R9
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(coin_ack && note_ack));

  // R4
  coin_once_chk: assert property (@(posedge clk) disable iff (rst)
    coin_ack |=> !coin_ack);

  // R4
  note_once_chk: assert property (@(posedge clk) disable iff (rst)
    note_ack |=> !note_ack);

  // R2
  coin_level_chk: assert property (@(posedge clk) disable iff (rst)
    coin_ack |-> $past(coin_half_in));

  // R3
  note_level_chk: assert property (@(posedge clk) disable iff (rst)
    note_ack |-> $past(note_one_in));

  // R6
  vend_needs_pay_chk: assert property (@(posedge clk) disable iff (rst)
    vend_pulse |-> (coin_ack || note_ack));

  // R2
  coin_add_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_ack && !vend_pulse) |-> int'(credit) == int'($past(credit)) + COIN_STEPS);

  // R7
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    (note_ack && vend_pulse) |->
      int'(credit) == int'($past(credit)) + NOTE_STEPS - PRICE_STEPS);

endmodule

bind snack_credit_ctrl vend_credit_chk #(
  .PRICE_STEPS (PRICE_STEPS),
  .COIN_STEPS  (COIN_STEPS),
  .NOTE_STEPS  (NOTE_STEPS),
  .CRED_W      (CRED_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .coin_half_in (coin_half_in),
  .note_one_in  (note_one_in),
  .coin_ack     (coin_ack),
  .note_ack     (note_ack),
  .vend_pulse   (vend_pulse),
  .credit       (credit_q)
);

// File: tb/tb_snack_credit_ctrl.sv
module tb_snack_credit_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  // Vector: {req[3:0], coin, note, exp_coin_ack, exp_note_ack, exp_vend}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd2, 5'b10_100},  // R2 coin -> 1
    {4'd2, 5'b00_000},
    {4'd2, 5'b10_100},  // R2 coin -> 2
    {4'd4, 5'b10_000},  // R4 held coin
    {4'd4, 5'b00_000},
    {4'd3, 5'b01_010},  // R3 note -> 4
    {4'd3, 5'b00_000},
    {4'd7, 5'b01_011},  // R7 note at 4 -> deliver, 1 left
    {4'd7, 5'b00_000},
    {4'd5, 5'b11_010},  // R5 both -> note only, 3
    {4'd5, 5'b10_000},  // R5 coin still high, not counted
    {4'd5, 5'b00_000},
    {4'd5, 5'b10_100},  // R5 coin re-raised -> 4
    {4'd6, 5'b00_000},
    {4'd6, 5'b10_101},  // R6 coin reaches 5 -> deliver, 0
    {4'd8, 5'b00_000},
    {4'd8, 5'b01_010},  // R8 note -> 2
    {4'd8, 5'b00_000},
    {4'd8, 5'b01_010},  // R8 note -> 4
    {4'd8, 5'b00_000},
    {4'd8, 5'b10_101},  // R8 exact -> deliver, 0
    {4'd8, 5'b00_000},
    {4'd3, 5'b01_010},  // R3 note -> 2
    {4'd4, 5'b01_000},  // R4 held note
    {4'd4, 5'b00_000},
    {4'd3, 5'b01_010},  // R3 note -> 4
    {4'd9, 5'b00_000},
    {4'd9, 5'b01_011},  // R9 one delivery, 1 left
    {4'd9, 5'b00_000},
    {4'd7, 5'b10_100},  // R7 coin -> 2
    {4'd7, 5'b00_000},
    {4'd7, 5'b01_010},  // R7 note -> 4
    {4'd7, 5'b00_000},
    {4'd7, 5'b10_101}   // R7 deliver, 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_half_in = 1'b0;
  logic note_one_in = 1'b0;
  logic coin_ack, note_ack, vend_pulse;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snack_credit_ctrl dut (
    .clk          (clk),
    .rst          (rst),
    .coin_half_in (coin_half_in),
    .note_one_in  (note_one_in),
    .coin_ack     (coin_ack),
    .note_ack     (note_ack),
    .vend_pulse   (vend_pulse)
  );

  task automatic check3(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {coin_ack, note_ack, vend_pulse};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {coin_ack,note_ack,vend} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic c, input logic n);
    coin_half_in = c;
    note_one_in  = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check3("R1 reset state", 3'b000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][4], VEC[i][3]);
      check3($sformatf("R%0d vector %0d", VEC[i][8:5], i), VEC[i][2:0]);
    end

    // R1: reset in the middle of a purchase drops the collected credit.
    step(1'b0, 1'b1); check3("R1 prep note", 3'b010);   // 2
    step(1'b0, 1'b0);
    step(1'b0, 1'b1); check3("R1 prep note", 3'b010);   // 4
    rst = 1'b1;
    step(1'b0, 1'b0); check3("R1 outputs in reset", 3'b000);
    rst = 1'b0;
    step(1'b1, 1'b0); check3("R1 coin after reset no vend", 3'b100); // 1
    step(1'b0, 1'b0);
    step(1'b0, 1'b1); check3("R1 note after reset no vend", 3'b010); // 3
    step(1'b0, 1'b0);
    step(1'b0, 1'b1); check3("R1 delivery at five", 3'b011);          // 0

    // R5: both together, then hold both; neither counts again.
    step(1'b0, 1'b0);
    step(1'b1, 1'b1); check3("R5 both rise", 3'b010);  // 2
    step(1'b1, 1'b1); check3("R5 both held", 3'b000);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0); check3("R5 coin re-raise", 3'b100); // 3
    step(1'b0, 1'b0);
    step(1'b0, 1'b1); check3("R6 note past price", 3'b011); // 0
    step(1'b0, 1'b0); check3("R9 idle no pulse", 3'b000);

    finish_run();
  end

endmodule